// File: doc/BRIEF.md
# One-Time Protection Lock Register Controller

This block models a small protection lock register that software can reach only through a dedicated command mode. The register holds three one-time-programmable bits. Bit 0 locks the secured sector. Bit 1 fixes the device in persistent protection mode. Bit 2 fixes it in password protection mode. A bit that has been programmed to one cannot be cleared again, neither by a later program command nor by reset.

The controller takes decoded commands. Each command is one `cmd_valid` cycle with a 2-bit opcode: 0 enters command mode, 1 programs, 2 reads and 3 exits. It also takes a main-memory access request. While command mode is active, main-memory access is blocked. If a main-memory request arrives before the exit command, the controller locks up in a hang state that only reset clears. A read returns data only after a parameterised access delay. A program whose result would hold both mode bits at once is refused and flagged as aborted.

Top module: `otp_lock_ctrl`

## Requirements
- R1: After reset the controller is in normal mode: `hang`, `abort` and `rd_valid` are 0, and `mem_en` equals `mem_req` in the same cycle.
- R2: In normal mode, every command other than enter (opcode 0) is ignored; a program (opcode 1) issued there leaves the lock bits unchanged.
- R3: While in command mode or in the hang state, `mem_en` is 0 even when `mem_req` is 1.
- R4: A `mem_req` sampled high in command mode puts the controller into the hang state from the next cycle. From then on `hang` is 1 and all commands are ignored until reset.
- R5: A program (opcode 1) in command mode ORs `cmd_data` into the lock bits (bit 0 secured sector, bit 1 persistent, bit 2 password). A zero data bit never clears a bit that is already set.
- R6: A program whose result would have both bit 1 and bit 2 set changes nothing. It raises `abort` for exactly the one cycle after the command.
- R7: After a read (opcode 2) in command mode, `rd_valid` is 0 for ACC_DELAY cycles and `rd_data` reads 0 meanwhile. From the ACC_DELAY-th clock edge after the command, `rd_valid` is 1 and `rd_data` equals the lock bits.
- R8: Exit (opcode 3) in command mode returns the controller to normal mode, where `mem_en` again follows `mem_req`.
- R9: Lock bits persist across reset and the hang state. `prot_mode` is `{bit2, bit1}`: 01 means persistent, 10 means password, and 00 means no mode has been chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears mode state but not the lock bits |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Opcode: 0 enter, 1 program, 2 read, 3 exit |
| cmd_data | input | 3 | Bits to program |
| mem_req | input | 1 | Main-memory access request |
| mem_en | output | 1 | Main-memory access granted |
| rd_data | output | 3 | Lock bits, 0 while not valid |
| rd_valid | output | 1 | Read data valid |
| abort | output | 1 | Program refused (one-cycle pulse) |
| hang | output | 1 | Controller hung; only reset clears it |
| prot_mode | output | 2 | Selected protection mode |

## Verification
The bench counts the cycles from a read command to `rd_valid`. A design with an off-by-one delay would expose data one cycle early or late. It programs the mode bit that would clash with one already set and checks both the `abort` pulse and the unchanged lock bits. A design that compared only `cmd_data` would let the second mode slip through. It drives `mem_req` inside command mode and then tries exit and reset. A design that let exit clear the hang, or that let reset wipe the one-time bits, shows a wrong `hang` or a wrong read-back value. It also programs in normal mode, where a design that decodes commands outside command mode would set bits.

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl #(
  parameter int ACC_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [2:0] cmd_data,
  input  logic       mem_req,
  output logic       mem_en,
  output logic [2:0] rd_data,
  output logic       rd_valid,
  output logic       abort,
  output logic       hang,
  output logic [1:0] prot_mode
);
  localparam int CW = $clog2(ACC_DELAY + 1);
  localparam logic [1:0] OP_ENTER = 2'd0, OP_PROG = 2'd1, OP_READ = 2'd2, OP_EXIT = 2'd3;

  typedef enum logic [1:0] {ST_NORM, ST_CMD, ST_HANG} st_t;
  st_t st_q;

  logic [2:0]    lock_q = '0;
  logic          pend_q, abort_q;
  logic [CW-1:0] cnt_q;

  wire in_cmd   = (st_q == ST_CMD);
  wire cmd_take = in_cmd && cmd_valid && !mem_req;
  wire [2:0] prog_val = lock_q | cmd_data;
  wire prog_bad = prog_val[1] && prog_val[2];

  always_ff @(posedge clk) begin
    if (cmd_take && cmd_op == OP_PROG && !prog_bad)
      lock_q <= prog_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_NORM;
    end else begin
      case (st_q)
        ST_NORM: if (cmd_valid && cmd_op == OP_ENTER) st_q <= ST_CMD;
        ST_CMD: begin
          if (mem_req) st_q <= ST_HANG;
          else if (cmd_valid && cmd_op == OP_EXIT) st_q <= ST_NORM;
        end
        default: st_q <= ST_HANG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= cmd_take && cmd_op == OP_PROG && prog_bad;
      if (cmd_take) begin
        pend_q <= (cmd_op == OP_READ);
        cnt_q  <= (cmd_op == OP_READ) ? CW'(ACC_DELAY) : '0;
      end else if (!in_cmd) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign mem_en    = (st_q == ST_NORM) && mem_req;
  assign rd_valid  = in_cmd && pend_q && (cnt_q == '0);
  assign rd_data   = rd_valid ? lock_q : 3'b000;
  assign abort     = abort_q;
  assign hang      = (st_q == ST_HANG);
  assign prot_mode = {lock_q[2], lock_q[1]};
endmodule

// File: rtl/otp_lock_chk.sv
module otp_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       mem_req,
  input logic       mem_en,
  input logic       rd_valid,
  input logic       abort,
  input logic       hang,
  input logic       in_cmd,
  input logic [2:0] lock_q
);
  a_r9_bits_never_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_q) & ~lock_q) == 3'b000);

  a_r6_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_q[1] && lock_q[2]));

  a_r6_abort_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> lock_q == $past(lock_q));

  a_r4_hang_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hang |=> hang);

  a_r4_req_in_cmd_hangs: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && mem_req) |=> hang);

  a_r3_no_mem_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd || hang) |-> !mem_en);

  a_r7_not_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && cmd_valid && cmd_op == 2'd2 && !mem_req) |=> !rd_valid);

  a_r8_exit_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && cmd_valid && cmd_op == 2'd3 && !mem_req) |=> (!in_cmd && !hang));
endmodule

bind otp_lock_ctrl otp_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .mem_req(mem_req), .mem_en(mem_en), .rd_valid(rd_valid), .abort(abort),
  .hang(hang), .in_cmd(in_cmd), .lock_q(lock_q)
);

// File: tb/otp_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_lock_ctrl_tb_top;
  localparam int D = 3;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, mem_req = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [2:0] cmd_data = '0;
  logic mem_en, rd_valid, abort, hang;
  logic [2:0] rd_data;
  logic [1:0] prot_mode;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  otp_lock_ctrl #(.ACC_DELAY(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .mem_req(mem_req), .mem_en(mem_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .abort(abort), .hang(hang), .prot_mode(prot_mode));

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [2:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0; cmd_data = '0;
  endtask

  task automatic read_lock(output logic [2:0] v);
    do_cmd(2'd2, 3'b000);
    repeat (D) @(negedge clk);
    v = rd_valid ? rd_data : 3'bxxx;
  endtask

  task automatic t_reset();
    logic [2:0] v;
    do_reset();
    check("R1 hang", {3'b0, hang}, 4'd0);
    check("R1 abort", {3'b0, abort}, 4'd0);
    check("R1 rd_valid", {3'b0, rd_valid}, 4'd0);
    mem_req = 1'b1; #0.5;
    check("R1 mem_en follows req", {3'b0, mem_en}, 4'd1);
    mem_req = 1'b0;
    check("R9 prot_mode none", {2'b0, prot_mode}, 4'd0);
    do_cmd(2'd1, 3'b001);
    do_cmd(2'd0, 3'b000);
    read_lock(v);
    check("R2 program ignored outside command mode", {1'b0, v}, 4'd0);
  endtask

  task automatic t_read_delay();
    do_cmd(2'd2, 3'b000);
    for (int i = 0; i < D; i++) begin
      check("R7 not valid yet", {3'b0, rd_valid}, 4'd0);
      check("R7 data zero while not valid", {1'b0, rd_data}, 4'd0);
      @(negedge clk);
    end
    check("R7 valid after delay", {3'b0, rd_valid}, 4'd1);
  endtask

  task automatic t_program();
    logic [2:0] v;
    do_cmd(2'd1, 3'b001);
    read_lock(v);
    check("R5 secured bit set", {1'b0, v}, 4'd1);
    do_cmd(2'd1, 3'b000);
    read_lock(v);
    check("R5 zero data keeps bit", {1'b0, v}, 4'd1);
    do_cmd(2'd1, 3'b010);
    read_lock(v);
    check("R5 persistent bit set", {1'b0, v}, 4'd3);
    check("R9 prot_mode persistent", {2'b0, prot_mode}, 4'd1);
  endtask

  task automatic t_abort();
    logic [2:0] v;
    do_cmd(2'd1, 3'b100);
    check("R6 abort pulse", {3'b0, abort}, 4'd1);
    @(negedge clk);
    check("R6 abort one cycle", {3'b0, abort}, 4'd0);
    read_lock(v);
    check("R6 bits unchanged", {1'b0, v}, 4'd3);
    check("R6 prot_mode unchanged", {2'b0, prot_mode}, 4'd1);
  endtask

  task automatic t_exit();
    do_cmd(2'd3, 3'b000);
    mem_req = 1'b1; #0.5;
    check("R8 mem_en after exit", {3'b0, mem_en}, 4'd1);
    @(negedge clk);
    check("R8 no hang after exit", {3'b0, hang}, 4'd0);
    mem_req = 1'b0;
  endtask

  task automatic t_hang();
    logic [2:0] v;
    do_cmd(2'd0, 3'b000);
    mem_req = 1'b1; #0.5;
    check("R3 mem blocked in command mode", {3'b0, mem_en}, 4'd0);
    @(negedge clk); mem_req = 1'b0;
    check("R4 hang entered", {3'b0, hang}, 4'd1);
    do_cmd(2'd3, 3'b000);
    do_cmd(2'd1, 3'b001);
    check("R4 exit ignored in hang", {3'b0, hang}, 4'd1);
    mem_req = 1'b1; #0.5;
    check("R3 mem blocked in hang", {3'b0, mem_en}, 4'd0);
    mem_req = 1'b0;
    do_reset();
    check("R4 reset clears hang", {3'b0, hang}, 4'd0);
    check("R9 mode kept after hang", {2'b0, prot_mode}, 4'd1);
    do_cmd(2'd0, 3'b000);
    read_lock(v);
    check("R9 bits kept across reset", {1'b0, v}, 4'd3);
    do_cmd(2'd3, 3'b000);
  endtask

  initial begin
    t_reset();
    t_read_delay();
    t_program();
    t_abort();
    t_exit();
    t_hang();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule